// File: doc/BRIEF.md
# Boundary-Scan Instruction and Data Register Unit

This unit holds the instruction register of a four-wire test access port and the data registers that can be placed between the serial input and the serial output. These are a one-bit bypass stage, a 32-bit device identifier and a boundary chain of input and output pin cells. It does not contain the port's state machine. That machine reports its state to the unit as one-hot strobes, each held for the whole test-clock cycle of its state. The unit acts on capture and shift at the rising test-clock edge, and on update and serial output at the falling edge.

The boundary chain sits on the path between core logic and the pads. In normal operation the output pins carry the core's values. While the external-test instruction is active, the output pins carry the chain's update stage. Input pins always feed the core directly. The sample/preload instruction takes a snapshot of the pins without disturbing them. It can also load the update stage in advance, so that a later external-test instruction drives known values from its first cycle. A self-test request line is raised while the self-test opcode is held. The engine behind that line is not part of this unit.

The serial test data interface is bit-serial and has no back-pressure. Every enabled shift cycle moves exactly one bit. The valid/ready convention therefore does not apply, and all pins are plain.

Top module: `jtag_bsu`

## Requirements
- R1: Opcode map of the 4-bit instruction: 4'b0000 external test, 4'b0001 sample/preload, 4'b0010 identify, 4'b0111 self-test request, 4'b1111 bypass. Both test opcodes (0000, 0001) select the boundary chain and identify selects the identifier. All other codes, the self-test code included, select the one-bit bypass stage. `bist_go` is high only while the active opcode is 4'b0111.
- R2: The instruction shift stage loads 4'b0001 in Capture-IR and shifts LSB first from `tdi` in Shift-IR. `active_op` takes the shifted value at the falling edge in Update-IR and changes at no other time except reset.
- R3: Asynchronous reset and the Test-Logic-Reset strobe both set `active_op` to 4'b0010 (identify).
- R4: The bypass stage captures 0 in Capture-DR, then delays `tdi` by exactly one shift.
- R5: Under identify, Capture-DR loads the 32-bit `ID_CODE` parameter with bit 0 forced to 1. It shifts out LSB first, and `tdi` follows after 32 bits.
- R6: Boundary chain layout: bits [N_IN-1:0] are input cells and bits [N_IN+N_OUT-1:N_IN] are output cells, with bit 0 nearest `tdo`. Under either test opcode, Capture-DR loads the input cells from `pin_in` and the output cells from the value currently on `pin_out`.
- R7: Under sample/preload, `pin_out` equals `core_out`. Update-DR copies the output cells of the shift stage into the update stage at the falling edge.
- R8: Under external test, `pin_out` equals the update stage. Apart from the instruction change itself, it changes only at the falling edge of a cycle in Update-DR.
- R9: `core_in` always equals `pin_in`. Values shifted into input cells never reach it.
- R10: `tdo` presents bit 0 of the selected register (the instruction stage in Shift-IR) and changes at the falling edge. `tdo_en` is high for exactly the shift cycles.
- R11: The boundary chain captures, shifts and updates only under the two test opcodes. Data scans under other opcodes leave its update stage unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| st_tlr | input | 1 | State strobe: Test-Logic-Reset |
| st_capture_ir | input | 1 | State strobe: Capture-IR |
| st_shift_ir | input | 1 | State strobe: Shift-IR |
| st_update_ir | input | 1 | State strobe: Update-IR |
| st_capture_dr | input | 1 | State strobe: Capture-DR |
| st_shift_dr | input | 1 | State strobe: Shift-DR |
| st_update_dr | input | 1 | State strobe: Update-DR |
| tdi | input | 1 | Serial test data in |
| tdo | output | 1 | Serial test data out |
| tdo_en | output | 1 | High while `tdo` carries shifted data |
| active_op | output | 4 | Instruction in force |
| bist_go | output | 1 | Self-test request |
| core_out | input | N_OUT | Values the core wants on output pins |
| pin_out | output | N_OUT | Values sent to output pads |
| pin_in | input | N_IN | Levels from input pads |
| core_in | output | N_IN | Input levels passed to the core |

## Verification
On every rising edge the assertions check the following. The instruction stays put outside Update-IR and Test-Logic-Reset, and Test-Logic-Reset yields identify. The first bit out of an instruction scan is the 1 of the capture pattern. `tdo_en` tracks the shift strobes. Under external test, the pins hold steady in every cycle that has no Update-DR. The scenarios are the only place where register contents can be shown. They cover the captured and shifted bit streams for all sixteen opcodes, the forced identifier bit, preload followed by external test, and the half-cycle timing of the pin change. They also show that scans under other opcodes leave the driven pins untouched.

// File: rtl/jtag_bsu_pkg.sv
`timescale 1ns/1ps
package jtag_bsu_pkg;
  localparam int unsigned OP_W = 4;

  localparam logic [OP_W-1:0] OP_EXTEST  = 4'b0000;
  localparam logic [OP_W-1:0] OP_SAMPRE  = 4'b0001;
  localparam logic [OP_W-1:0] OP_IDCODE  = 4'b0010;
  localparam logic [OP_W-1:0] OP_RUNBIST = 4'b0111;
  localparam logic [OP_W-1:0] OP_BYPASS  = 4'b1111;

  // fixed pattern captured into the instruction shift stage
  localparam logic [OP_W-1:0] IR_CAPTURE = 4'b0001;

  typedef enum logic [1:0] {
    SEL_BSR = 2'd0,
    SEL_ID  = 2'd1,
    SEL_BYP = 2'd2
  } dr_sel_e;
endpackage

// File: rtl/jtag_bsu_ir.sv
`timescale 1ns/1ps
module jtag_bsu_ir
  import jtag_bsu_pkg::*;
(
  input  logic            tck,
  input  logic            rst_n,
  input  logic            st_tlr,
  input  logic            st_capture_ir,
  input  logic            st_shift_ir,
  input  logic            st_update_ir,
  input  logic            tdi,
  output logic            ir_lsb,
  output logic [OP_W-1:0] op,
  output dr_sel_e         sel,
  output logic            drive_pins,
  output logic            bist_go
);
  logic [OP_W-1:0] ir_sh;

  // rising edge: capture and shift
  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)             ir_sh <= IR_CAPTURE;
    else if (st_capture_ir) ir_sh <= IR_CAPTURE;
    else if (st_shift_ir)   ir_sh <= {tdi, ir_sh[OP_W-1:1]};
  end

  // falling edge: instruction takes effect
  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n)            op <= OP_IDCODE;
    else if (st_tlr)       op <= OP_IDCODE;
    else if (st_update_ir) op <= ir_sh;
  end

  assign ir_lsb = ir_sh[0];

  always_comb begin
    sel        = SEL_BYP;
    drive_pins = 1'b0;
    bist_go    = 1'b0;
    case (op)
      OP_EXTEST: begin
        sel        = SEL_BSR;
        drive_pins = 1'b1;
      end
      OP_SAMPRE:  sel = SEL_BSR;
      OP_IDCODE:  sel = SEL_ID;
      OP_RUNBIST: bist_go = 1'b1;
      default:    sel = SEL_BYP;
    endcase
  end
endmodule

// File: rtl/jtag_bsu_idbyp.sv
`timescale 1ns/1ps
module jtag_bsu_idbyp
  import jtag_bsu_pkg::*;
#(
  parameter int unsigned   ID_W    = 32,
  parameter logic [ID_W-1:0] ID_CODE = '1
)(
  input  logic    tck,
  input  logic    rst_n,
  input  logic    st_capture_dr,
  input  logic    st_shift_dr,
  input  dr_sel_e sel,
  input  logic    tdi,
  output logic    id_lsb,
  output logic    byp_lsb
);
  localparam logic [ID_W-1:0] ID_VAL = {ID_CODE[ID_W-1:1], 1'b1};

  logic [ID_W-1:0] id_sh;
  logic            byp_q;

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      id_sh <= ID_VAL;
    end else if (sel == SEL_ID) begin
      if (st_capture_dr)    id_sh <= ID_VAL;
      else if (st_shift_dr) id_sh <= {tdi, id_sh[ID_W-1:1]};
    end
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      byp_q <= 1'b0;
    end else if (sel == SEL_BYP) begin
      if (st_capture_dr)    byp_q <= 1'b0;
      else if (st_shift_dr) byp_q <= tdi;
    end
  end

  assign id_lsb  = id_sh[0];
  assign byp_lsb = byp_q;
endmodule

// File: rtl/jtag_bsu_chain.sv
`timescale 1ns/1ps
module jtag_bsu_chain #(
  parameter int unsigned N_IN  = 4,
  parameter int unsigned N_OUT = 4
)(
  input  logic             tck,
  input  logic             rst_n,
  input  logic             st_capture_dr,
  input  logic             st_shift_dr,
  input  logic             st_update_dr,
  input  logic             chain_en,
  input  logic             drive_pins,
  input  logic             tdi,
  input  logic [N_IN-1:0]  pin_in,
  input  logic [N_OUT-1:0] core_out,
  output logic [N_OUT-1:0] pin_out,
  output logic             chain_lsb
);
  localparam int unsigned LEN = N_IN + N_OUT;

  logic [LEN-1:0]   sh_q;
  logic [N_OUT-1:0] upd_q;

  for (genvar g = 0; g < LEN; g++) begin : g_cell
    logic cap_v;
    logic nxt_v;
    if (g < N_IN) begin : g_in
      assign cap_v = pin_in[g];
    end else begin : g_out
      assign cap_v = pin_out[g-N_IN];
    end
    if (g == LEN-1) begin : g_head
      assign nxt_v = tdi;
    end else begin : g_link
      assign nxt_v = sh_q[g+1];
    end

    always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n)                         sh_q[g] <= 1'b0;
      else if (chain_en && st_capture_dr) sh_q[g] <= cap_v;
      else if (chain_en && st_shift_dr)   sh_q[g] <= nxt_v;
    end
  end

  // update (slave) stage exists only for output cells
  for (genvar j = 0; j < N_OUT; j++) begin : g_upd
    always_ff @(negedge tck or negedge rst_n) begin
      if (!rst_n)                        upd_q[j] <= 1'b0;
      else if (chain_en && st_update_dr) upd_q[j] <= sh_q[N_IN+j];
    end
    assign pin_out[j] = drive_pins ? upd_q[j] : core_out[j];
  end

  assign chain_lsb = sh_q[0];
endmodule

// File: rtl/jtag_bsu.sv
`timescale 1ns/1ps
module jtag_bsu
  import jtag_bsu_pkg::*;
#(
  parameter int unsigned N_IN    = 4,
  parameter int unsigned N_OUT   = 4,
  parameter logic [31:0] ID_CODE = 32'h1A2B_3C4D
)(
  input  logic             tck,
  input  logic             rst_n,
  input  logic             st_tlr,
  input  logic             st_capture_ir,
  input  logic             st_shift_ir,
  input  logic             st_update_ir,
  input  logic             st_capture_dr,
  input  logic             st_shift_dr,
  input  logic             st_update_dr,
  input  logic             tdi,
  output logic             tdo,
  output logic             tdo_en,
  output logic [3:0]       active_op,
  output logic             bist_go,
  input  logic [N_OUT-1:0] core_out,
  output logic [N_OUT-1:0] pin_out,
  input  logic [N_IN-1:0]  pin_in,
  output logic [N_IN-1:0]  core_in
);
  dr_sel_e sel;
  logic    ir_lsb, id_lsb, byp_lsb, chain_lsb, dr_lsb, drive_pins;

  jtag_bsu_ir u_ir (
    .tck(tck), .rst_n(rst_n), .st_tlr(st_tlr),
    .st_capture_ir(st_capture_ir), .st_shift_ir(st_shift_ir),
    .st_update_ir(st_update_ir), .tdi(tdi), .ir_lsb(ir_lsb),
    .op(active_op), .sel(sel), .drive_pins(drive_pins), .bist_go(bist_go)
  );

  jtag_bsu_idbyp #(.ID_W(32), .ID_CODE(ID_CODE)) u_idbyp (
    .tck(tck), .rst_n(rst_n), .st_capture_dr(st_capture_dr),
    .st_shift_dr(st_shift_dr), .sel(sel), .tdi(tdi),
    .id_lsb(id_lsb), .byp_lsb(byp_lsb)
  );

  jtag_bsu_chain #(.N_IN(N_IN), .N_OUT(N_OUT)) u_chain (
    .tck(tck), .rst_n(rst_n), .st_capture_dr(st_capture_dr),
    .st_shift_dr(st_shift_dr), .st_update_dr(st_update_dr),
    .chain_en(sel == SEL_BSR), .drive_pins(drive_pins), .tdi(tdi),
    .pin_in(pin_in), .core_out(core_out), .pin_out(pin_out),
    .chain_lsb(chain_lsb)
  );

  always_comb begin
    case (sel)
      SEL_BSR: dr_lsb = chain_lsb;
      SEL_ID:  dr_lsb = id_lsb;
      default: dr_lsb = byp_lsb;
    endcase
  end

  // serial output moves on the falling edge
  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n) begin
      tdo    <= 1'b0;
      tdo_en <= 1'b0;
    end else begin
      tdo_en <= st_shift_ir | st_shift_dr;
      if (st_shift_ir)      tdo <= ir_lsb;
      else if (st_shift_dr) tdo <= dr_lsb;
    end
  end

  // input pins go straight to the core
  assign core_in = pin_in;
endmodule

// File: rtl/jtag_bsu_chk.sv
`timescale 1ns/1ps
module jtag_bsu_chk #(
  parameter int unsigned N_OUT = 4
)(
  input logic             tck,
  input logic             rst_n,
  input logic             st_tlr,
  input logic             st_capture_ir,
  input logic             st_shift_ir,
  input logic             st_update_ir,
  input logic             st_shift_dr,
  input logic             st_update_dr,
  input logic             tdo,
  input logic             tdo_en,
  input logic [3:0]       active_op,
  input logic [N_OUT-1:0] pin_out
);
  // R2: instruction holds outside Update-IR and Test-Logic-Reset
  a_r2_op_hold: assert property (@(posedge tck) disable iff (!rst_n)
    (!st_update_ir && !st_tlr) |-> $stable(active_op));

  // R2: first bit of an instruction scan is the captured 1
  a_r2_ir_capture: assert property (@(posedge tck) disable iff (!rst_n)
    ($past(st_capture_ir) && st_shift_ir) |-> tdo);

  // R3: Test-Logic-Reset leaves identify in force
  a_r3_tlr_idcode: assert property (@(posedge tck) disable iff (!rst_n)
    st_tlr |-> (active_op == 4'b0010));

  // R10: output enable follows the shift states
  a_r10_tdo_en: assert property (@(posedge tck) disable iff (!rst_n)
    tdo_en == (st_shift_ir | st_shift_dr));

  // R8: driven pins hold in every extest cycle without Update-DR
  a_r8_pin_hold: assert property (@(posedge tck) disable iff (!rst_n)
    (active_op == 4'b0000 && $past(active_op) == 4'b0000 && !st_update_dr)
      |-> $stable(pin_out));
endmodule

bind jtag_bsu jtag_bsu_chk #(.N_OUT(N_OUT)) u_chk (
  .tck(tck), .rst_n(rst_n), .st_tlr(st_tlr),
  .st_capture_ir(st_capture_ir), .st_shift_ir(st_shift_ir),
  .st_update_ir(st_update_ir), .st_shift_dr(st_shift_dr),
  .st_update_dr(st_update_dr), .tdo(tdo), .tdo_en(tdo_en),
  .active_op(active_op), .pin_out(pin_out)
);

// File: tb/jtag_bsu_tb.sv
`timescale 1ns/1ps
module jtag_bsu_tb;
  localparam int unsigned N_IN  = 4;
  localparam int unsigned N_OUT = 4;
  localparam int unsigned LEN   = N_IN + N_OUT;
  localparam logic [31:0] ID_RAW = 32'h5B3D_A0C6;   // bit 0 clear on purpose
  localparam logic [31:0] ID_EXP = 32'h5B3D_A0C7;
  localparam int unsigned NSH   = 40;

  // strobe order: tlr, cap_ir, sh_ir, up_ir, cap_dr, sh_dr, up_dr
  localparam logic [6:0] S_IDLE = 7'b0000000;
  localparam logic [6:0] S_TLR  = 7'b1000000;
  localparam logic [6:0] S_CIR  = 7'b0100000;
  localparam logic [6:0] S_SIR  = 7'b0010000;
  localparam logic [6:0] S_UIR  = 7'b0001000;
  localparam logic [6:0] S_CDR  = 7'b0000100;
  localparam logic [6:0] S_SDR  = 7'b0000010;
  localparam logic [6:0] S_UDR  = 7'b0000001;

  // per opcode: [2]=bist_go, [1:0]=kind (0 chain, 1 identifier, 2 bypass)
  localparam logic [2:0] EXP_OP [16] = '{
    3'b000, 3'b000, 3'b001, 3'b010, 3'b010, 3'b010, 3'b010, 3'b110,
    3'b010, 3'b010, 3'b010, 3'b010, 3'b010, 3'b010, 3'b010, 3'b010
  };

  logic tck = 1'b0, rst_n = 1'b0;
  logic st_tlr = 0, st_capture_ir = 0, st_shift_ir = 0, st_update_ir = 0;
  logic st_capture_dr = 0, st_shift_dr = 0, st_update_dr = 0, tdi = 0;
  logic tdo, tdo_en, bist_go;
  logic [3:0] active_op;
  logic [N_OUT-1:0] core_out = '0, pin_out;
  logic [N_IN-1:0]  pin_in = '0, core_in;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #10 tck = ~tck;   // 50 MHz

  jtag_bsu #(.N_IN(N_IN), .N_OUT(N_OUT), .ID_CODE(ID_RAW)) u_dut (
    .tck(tck), .rst_n(rst_n), .st_tlr(st_tlr),
    .st_capture_ir(st_capture_ir), .st_shift_ir(st_shift_ir),
    .st_update_ir(st_update_ir), .st_capture_dr(st_capture_dr),
    .st_shift_dr(st_shift_dr), .st_update_dr(st_update_dr),
    .tdi(tdi), .tdo(tdo), .tdo_en(tdo_en), .active_op(active_op),
    .bist_go(bist_go), .core_out(core_out), .pin_out(pin_out),
    .pin_in(pin_in), .core_in(core_in)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input logic [6:0] s, input logic d);
    @(posedge tck); #1;
    {st_tlr, st_capture_ir, st_shift_ir, st_update_ir,
     st_capture_dr, st_shift_dr, st_update_dr} = s;
    tdi = d;
  endtask

  task automatic scan_ir(input logic [3:0] op, output logic [3:0] dout);
    tick(S_CIR, 1'b0);
    for (int i = 0; i < 4; i++) begin
      tick(S_SIR, op[i]); #12; dout[i] = tdo;
    end
    tick(S_UIR, 1'b0);
    tick(S_IDLE, 1'b0);
  endtask

  task automatic scan_dr_body(input int n, input logic [63:0] din, output logic [63:0] dout);
    dout = '0;
    tick(S_CDR, 1'b0);
    for (int i = 0; i < n; i++) begin
      tick(S_SDR, din[i]); #12; dout[i] = tdo;
    end
  endtask

  task automatic scan_dr(input int n, input logic [63:0] din, output logic [63:0] dout);
    scan_dr_body(n, din, dout);
    tick(S_UDR, 1'b0);
    tick(S_IDLE, 1'b0);
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [3:0]  irout;
    logic [63:0] din, dout, expv;
    logic [N_OUT-1:0] upd_model;
    logic [LEN-1:0]   cap;
    upd_model = '0;

    #35; rst_n = 1'b1;
    tick(S_IDLE, 1'b0); #5;
    // R3, R10, R8: reset state
    check("R3 reset opcode", 64'(active_op), 64'h2);
    check("R10 reset tdo_en", 64'(tdo_en), 64'h0);
    check("R8 reset pins follow core", 64'(pin_out), 64'(core_out));

    // table walk over all opcodes
    for (int op = 0; op < 16; op++) begin
      logic [1:0] kind;
      kind     = EXP_OP[op][1:0];
      pin_in   = 4'(op) ^ 4'h5;
      core_out = ~4'(op);
      scan_ir(4'(op), irout);
      check("R2 ir capture pattern", 64'(irout), 64'h1);
      check("R1 active opcode", 64'(active_op), 64'(op));
      check("R1 bist_go", 64'(bist_go), 64'(EXP_OP[op][2]));
      din = 64'(40'hC35A96E10F ^ (40'(op) * 40'h0101010101));
      cap = {(op == 0) ? upd_model : core_out, pin_in};
      scan_dr(NSH, din, dout);
      case (kind)
        2'd0:    expv = 64'({din[31:0], cap});
        2'd1:    expv = 64'({din[7:0], ID_EXP});
        default: expv = 64'({din[38:0], 1'b0});
      endcase
      if (kind == 2'd0) begin
        upd_model = din[NSH-1 -: N_OUT];
        check("R6 chain capture and shift", dout, expv);
      end else if (kind == 2'd1) check("R5 identifier stream", dout, expv);
      else                       check("R4 bypass stream", dout, expv);
      if (op == 0) check("R8 extest drives update stage", 64'(pin_out), 64'(upd_model));
      else         check("R7 pins follow core", 64'(pin_out), 64'(core_out));
      check("R9 core_in from pins", 64'(core_in), 64'(pin_in));
    end

    // R7 then R8: preload under sample/preload, then extest applies it
    core_out = 4'h3;
    scan_ir(4'b0001, irout);
    scan_dr(LEN, 64'hA6, dout);                 // output cells get 4'hA
    check("R7 pins stay with core after preload", 64'(pin_out), 64'h3);
    scan_ir(4'b0000, irout);
    check("R8 extest drives preloaded value", 64'(pin_out), 64'hA);

    // R8: change lands at the falling edge of Update-DR
    pin_in = 4'h9;
    scan_dr_body(LEN, 64'h56, dout);            // output cells get 4'h5, inputs 4'h6
    tick(S_UDR, 1'b0);
    #4;  check("R8 pins held before falling edge", 64'(pin_out), 64'hA);
    #8;  check("R8 pins updated after falling edge", 64'(pin_out), 64'h5);
    tick(S_IDLE, 1'b0);
    // R9: shifted input-cell value 6 does not reach the core
    check("R9 core_in ignores chain", 64'(core_in), 64'h9);

    // R11: scans under bypass leave the update stage alone
    scan_ir(4'b1111, irout);
    scan_dr(LEN, 64'hF0, dout);
    scan_ir(4'b0000, irout);
    check("R11 update stage kept across bypass scan", 64'(pin_out), 64'h5);

    // R10: enable during a shift cycle, first bit is captured LSB
    tick(S_CDR, 1'b0);
    tick(S_SDR, 1'b0); #12;
    check("R10 tdo_en in shift", 64'(tdo_en), 64'h1);
    check("R10 tdo shows chain bit 0 (pin_in[0])", 64'(tdo), 64'(pin_in[0]));
    tick(S_IDLE, 1'b0); #12;
    check("R10 tdo_en off after shift", 64'(tdo_en), 64'h0);

    // R3: Test-Logic-Reset returns identify and releases pins
    core_out = 4'hC;
    tick(S_TLR, 1'b0);
    tick(S_IDLE, 1'b0); #2;
    check("R3 tlr opcode", 64'(active_op), 64'h2);
    check("R3 tlr pins back to core", 64'(pin_out), 64'hC);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule